// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the target side of a two-wire serial bus in front of a 256-byte memory. It runs on a system clock far faster than the bus clock. It passes both bus lines through synchronizers and finds START and STOP conditions and clock edges on the synchronized copies. It drives the data line only as an active-low open-drain enable. It accepts a control byte whose upper nibble is a fixed code. It loads an 8-bit word pointer from the byte that follows a write control byte. It hands each later data byte to an external page-write unit.

Reads take data from a combinational memory read port addressed by the pointer. One persistent pointer serves current-address reads, random reads (a repeated START follows the word address) and sequential reads. While the page-write unit reports an internal write in progress, the engine withholds the acknowledge of the control byte. A bus master can therefore poll until the write finishes.

Top module: `serial_mem_target`

## Requirements
- R1: After reset the data line is released (`sda_oe` = 0) and the word pointer is 0. A current-address read issued before any other access returns the byte at address 0.
- R2: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. Bits are sampled on the SCL high phase, most significant bit first.
- R3: The engine accepts a control byte only when bits 7..4 equal 4'b1010. Bits 3..1 are ignored and bit 0 picks read (1) or write (0). Any other control byte gets no acknowledge, and the engine ignores the bus until the next START.
- R4: An acknowledge holds SDA low for the whole high phase of the ninth SCL pulse. `sda_oe` changes only after an SCL falling edge, a START or a STOP.
- R5: While `wr_busy` is 1, a matching control byte is not acknowledged. The first control byte that arrives after `wr_busy` clears is acknowledged.
- R6: In a write transaction the first byte after the control byte loads the pointer. Each later byte is pushed with the pointer as its address. The pointer's low 3 bits then advance by one and wrap inside an 8-byte page, while bits 7..3 stay fixed.
- R7: A STOP that follows at least one pushed data byte pulses `wr_commit`. A repeated START that follows pushed data pulses `wr_drop` instead. A transaction with no data byte produces neither pulse.
- R8: A repeated START after the word address, followed by a read control byte, returns the byte at that address.
- R9: A read control byte returns the byte at the pointer, and each byte sent advances the pointer by one. So a current-address read returns the byte after the last one accessed.
- R10: When the master acknowledges a read byte, the next sequential byte follows. The pointer wraps from 255 to 0.
- R11: When the master does not acknowledge a read byte, SDA stays released for all further SCL pulses until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| rd_addr | output | 8 | Memory read address (the word pointer) |
| rd_data | input | 8 | Memory read data for `rd_addr`, combinational |
| wr_busy | input | 1 | Page-write unit is programming |
| wr_push | output | 1 | One-cycle strobe: `wr_addr`/`wr_data` hold a data byte |
| wr_addr | output | 8 | Address of the pushed byte |
| wr_data | output | 8 | Pushed data byte |
| wr_commit | output | 1 | One-cycle strobe: program the pushed bytes |
| wr_drop | output | 1 | One-cycle strobe: discard the pushed bytes |

## Verification
The bench aims at the page boundary. A write that starts at 0x3D must land its fourth byte at 0x38; a design that carried into bit 3 would corrupt the next page. A sequential read across 0xFF must return address 0x00 next, and a pointer that saturated or that advanced only on the master's acknowledge would repeat a byte. A repeated START after pushed data must neither program memory nor lose the pointer advance, and a wrong control nibble followed by a valid-looking byte with no START must stay unacknowledged. Acknowledge polling must see at least one refusal right after a commit; an engine that ignored `wr_busy` would acknowledge at once.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_MACK,
    S_SKIP
  } tsm_state_e;

  typedef enum logic [1:0] {
    ROLE_CTRL,
    ROLE_ADDR,
    ROLE_DATA
  } tsm_role_e;

  localparam logic [3:0] CTRL_CODE = 4'b1010;
endpackage

// File: rtl/tsm_sync.sv
module tsm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tsm_cond.sv
module tsm_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = !scl_q && scl_s;
  assign scl_fall = scl_q && !scl_s;
  // Data moving while the clock stays high marks a bus condition
  assign start_ev = scl_q && scl_s && sda_q && !sda_s;
  assign stop_ev  = scl_q && scl_s && !sda_q && sda_s;
endmodule

// File: rtl/tsm_xfer.sv
module tsm_xfer
  import tsm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_s,
  input  logic              wr_busy,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_push,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_commit,
  output logic              wr_drop
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] TX_LAST  = CNT_W'(DATA_W - 1);

  // Write addresses advance only inside the current page
  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] lo;
    lo = a[PAGE_W-1:0] + 1'b1;
    return {a[ADDR_W-1:PAGE_W], lo};
  endfunction

  // Reads advance over the whole array and wrap at the top
  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  tsm_state_e        state;
  tsm_role_e         role;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] tx;
  logic [ADDR_W-1:0] ptr;
  logic              rw, dirty, mack;

  // Named internal events
  logic byte_done, ctrl_hit, ctrl_take;
  assign byte_done = (state == S_RX) && scl_fall && (cnt == BYTE_END);
  assign ctrl_hit  = (sh[DATA_W-1 -: 4] == CTRL_CODE);
  assign ctrl_take = ctrl_hit && !wr_busy;

  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      role      <= ROLE_CTRL;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      ptr       <= '0;
      rw        <= 1'b0;
      dirty     <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      wr_push   <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
      wr_drop   <= 1'b0;
    end else begin
      wr_push   <= 1'b0;
      wr_commit <= 1'b0;
      wr_drop   <= 1'b0;
      if (start_ev) begin
        state   <= S_RX;
        role    <= ROLE_CTRL;
        cnt     <= '0;
        sda_oe  <= 1'b0;
        wr_drop <= dirty;
        dirty   <= 1'b0;
      end else if (stop_ev) begin
        state     <= S_IDLE;
        sda_oe    <= 1'b0;
        wr_commit <= dirty;
        dirty     <= 1'b0;
      end else begin
        unique case (state)
          S_RX: begin
            if (scl_rise && cnt != BYTE_END) begin
              sh  <= {sh[DATA_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (byte_done) begin
              unique case (role)
                ROLE_CTRL: begin
                  if (ctrl_take) begin
                    rw     <= sh[0];
                    sda_oe <= 1'b1;
                    state  <= S_ACK;
                  end else begin
                    state  <= S_SKIP;
                  end
                end
                ROLE_ADDR: begin
                  ptr    <= sh[ADDR_W-1:0];
                  sda_oe <= 1'b1;
                  state  <= S_ACK;
                end
                default: begin
                  wr_push <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= sh;
                  ptr     <= page_next(ptr);
                  dirty   <= 1'b1;
                  sda_oe  <= 1'b1;
                  state   <= S_ACK;
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (role == ROLE_CTRL && rw) begin
                tx     <= rd_data;
                sda_oe <= !rd_data[DATA_W-1];
                ptr    <= seq_next(ptr);
                state  <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                role   <= (role == ROLE_CTRL) ? ROLE_ADDR : ROLE_DATA;
                state  <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == TX_LAST) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                state  <= S_MACK;
              end else begin
                tx     <= {tx[DATA_W-2:0], 1'b0};
                sda_oe <= !tx[DATA_W-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) mack <= !sda_s;
            if (scl_fall) begin
              if (mack) begin
                tx     <= rd_data;
                sda_oe <= !rd_data[DATA_W-1];
                ptr    <= seq_next(ptr);
                state  <= S_TX;
              end else begin
                state  <= S_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Checker state: page of the first push in a transaction
  logic              push_seen;
  logic [ADDR_W-1:PAGE_W] page_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_seen <= 1'b0;
      page_q    <= '0;
    end else if (start_ev || stop_ev) begin
      push_seen <= 1'b0;
    end else if (wr_push && !push_seen) begin
      push_seen <= 1'b1;
      page_q    <= wr_addr[ADDR_W-1:PAGE_W];
    end
  end

  // R4
  oe_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_ev || stop_ev));

  // R5
  ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && $past(state == S_RX && role == ROLE_CTRL)) |-> $past(ctrl_hit && !wr_busy));

  // R6
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_push && push_seen) |-> (wr_addr[ADDR_W-1:PAGE_W] == page_q));

  // R7
  commit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(stop_ev));

  // R7
  drop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |-> $past(start_ev));

  // R11
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SKIP) |-> !sda_oe);
endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              wr_busy,
  output logic              wr_push,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_commit,
  output logic              wr_drop
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  tsm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));

  tsm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

  tsm_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  tsm_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .sda_s(sda_s), .wr_busy(wr_busy), .rd_data(rd_data),
    .sda_oe(sda_oe), .rd_addr(rd_addr),
    .wr_push(wr_push), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_commit(wr_commit), .wr_drop(wr_drop));
endmodule

// File: tb/tb_serial_mem_target.sv
`timescale 1ns/1ps
module tb_serial_mem_target;
  localparam int Q       = 10;
  localparam int BUSY_CY = 600;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic m_scl, m_sda;
  logic sda_oe, wr_busy, wr_push, wr_commit, wr_drop;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
  wire sda_line = m_sda & ~sda_oe;

  serial_mem_target dut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .rd_addr(rd_addr), .rd_data(rd_data), .wr_busy(wr_busy),
    .wr_push(wr_push), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_commit(wr_commit), .wr_drop(wr_drop));

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 7 + 3);
  endfunction

  // Page-write unit and storage array model
  logic [7:0] mem  [256];
  logic [7:0] pend [256];
  logic       pv   [256];
  int busy_cnt, n_commit, n_drop, n_push;
  assign wr_busy = (busy_cnt != 0);
  assign rd_data = mem[rd_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin
        mem[i] <= init_val(i);
        pv[i]  <= 1'b0;
      end
      busy_cnt <= 0; n_commit <= 0; n_drop <= 0; n_push <= 0;
    end else begin
      if (wr_push) begin
        pend[wr_addr] <= wr_data;
        pv[wr_addr]   <= 1'b1;
        n_push        <= n_push + 1;
      end
      if (wr_drop) begin
        for (int i = 0; i < 256; i++) pv[i] <= 1'b0;
        n_drop <= n_drop + 1;
      end
      if (wr_commit) begin
        busy_cnt <= BUSY_CY;
        n_commit <= n_commit + 1;
      end else if (busy_cnt == 1) begin
        for (int i = 0; i < 256; i++) begin
          if (pv[i]) mem[i] <= pend[i];
          pv[i] <= 1'b0;
        end
        busy_cnt <= 0;
      end else if (busy_cnt != 0) begin
        busy_cnt <= busy_cnt - 1;
      end
    end
  end

  // Expected contents, kept by the test itself
  logic [7:0] model [256];
  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hq(); m_scl = 1'b1; hq(); m_sda = 1'b0; hq(); m_scl = 1'b0; hq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hq(); m_scl = 1'b1; hq(); m_sda = 1'b1; hq();
  endtask

  // Acknowledge counts only if SDA is low early and late in the high phase
  task automatic put_byte(input logic [7:0] b, output bit acked);
    bit early;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hq(); m_scl = 1'b1; hq(); m_scl = 1'b0; hq();
    end
    m_sda = 1'b1; hq(); m_scl = 1'b1;
    repeat (2) @(posedge clk);
    #1 early = !sda_line;
    hq();
    acked = early && !sda_line;
    m_scl = 1'b0; hq();
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hq(); m_scl = 1'b1; hq(); b[i] = sda_line; m_scl = 1'b0;
    end
    m_sda = give_ack ? 1'b0 : 1'b1;
    hq(); m_scl = 1'b1; hq(); m_scl = 1'b0; hq(); m_sda = 1'b1;
  endtask

  task automatic poll(output int tries);
    bit a;
    tries = 0;
    forever begin
      bus_start(); put_byte(8'hA0, a); bus_stop();
      tries++;
      if (a || tries > 40) break;
    end
  endtask

  localparam logic [23:0] VEC [6] = '{
    24'hA0_05_11, 24'hAE_2A_7C, 24'hA4_80_C3,
    24'hA2_FF_01, 24'hAA_90_55, 24'hA6_41_EE};

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit a, a2, a3;
    logic [7:0] b;
    int tries, lows, c0, d0, p0;
    for (int i = 0; i < 256; i++) model[i] = init_val(i);
    m_scl = 1'b1; m_sda = 1'b1; rst_n = 1'b0;
    repeat (10) @(posedge clk);
    #1 rst_n = 1'b1;
    hq();

    // R1 reset state
    check(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    bus_start(); put_byte(8'hA1, a); get_byte(1'b0, b); bus_stop();
    check(a, "R4 control ack", a, 1);
    check(b == model[0], "R1 R9 first current read", b, model[0]);
    bus_start(); put_byte(8'hA1, a); get_byte(1'b0, b); bus_stop();
    check(b == model[1], "R9 pointer advanced", b, model[1]);

    // Vector table: byte write, acknowledge polling, random read
    foreach (VEC[k]) begin
      logic [7:0] cw, ad, dt;
      {cw, ad, dt} = VEC[k];
      bus_start(); put_byte(cw, a); put_byte(ad, a2); put_byte(dt, a3); bus_stop();
      model[ad] = dt;
      check(a && a2 && a3, "R3 R6 write acks", {a, a2, a3}, 3'b111);
      poll(tries);
      check(tries > 1 && tries <= 40, "R5 busy refusal then ack", tries, 2);
      bus_start(); put_byte(cw, a); put_byte(ad, a2);
      bus_start(); put_byte(cw | 8'h01, a3); get_byte(1'b0, b); bus_stop();
      check(b == model[ad], "R2 R8 random read", b, model[ad]);
    end
    bus_start(); put_byte(8'hA1, a); get_byte(1'b0, b); bus_stop();
    check(b == model[8'h42], "R9 current after random", b, model[8'h42]);

    // Page write crossing the page end: 3D 3E 3F 38
    bus_start(); put_byte(8'hA0, a); put_byte(8'h3D, a);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] wa;
      wa = {5'b00111, 3'(3'd5 + k[2:0])};
      put_byte(8'hB0 + 8'(k), a);
      model[wa] = 8'hB0 + 8'(k);
    end
    bus_stop();
    poll(tries);
    bus_start(); put_byte(8'hA0, a); put_byte(8'h38, a);
    bus_start(); put_byte(8'hA1, a); get_byte(1'b0, b); bus_stop();
    check(b == 8'hB3, "R6 page wrap byte", b, 8'hB3);
    check(model[8'h40] == init_val(8'h40), "R6 next page untouched (model)", model[8'h40], init_val(8'h40));
    bus_start(); put_byte(8'hA0, a); put_byte(8'h3D, a);
    bus_start(); put_byte(8'hA1, a);
    for (int k = 0; k < 3; k++) begin
      get_byte(k != 2, b);
      check(b == 8'hB0 + 8'(k), "R10 sequential page bytes", b, 8'hB0 + 8'(k));
    end
    bus_stop();
    bus_start(); put_byte(8'hA1, a); get_byte(1'b0, b); bus_stop();
    check(b == model[8'h40], "R6 R9 no write past page", b, model[8'h40]);

    // Sequential read across the top of the array
    bus_start(); put_byte(8'hA0, a); put_byte(8'hFE, a);
    bus_start(); put_byte(8'hA1, a);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] ea;
      ea = 8'hFE + 8'(k);
      get_byte(k != 3, b);
      check(b == model[ea], "R10 wrap read", b, model[ea]);
    end
    bus_stop();

    // Wrong control code, then a valid-looking byte with no START
    p0 = n_push;
    bus_start(); put_byte(8'h90, a); put_byte(8'hA0, a2); put_byte(8'h05, a3); bus_stop();
    check(!a, "R3 bad code not acked", a, 0);
    check(!a2 && !a3, "R3 ignored until START", {a2, a3}, 0);
    check(n_push == p0, "R3 no push after bad code", n_push, p0);

    // Repeated START after pushed data drops it
    c0 = n_commit; d0 = n_drop;
    bus_start(); put_byte(8'hA0, a); put_byte(8'h10, a); put_byte(8'hEE, a);
    bus_start(); put_byte(8'hA1, a); get_byte(1'b0, b); bus_stop();
    check(b == model[8'h11], "R7 R9 pointer kept after drop", b, model[8'h11]);
    check(n_commit == c0 && n_drop == d0 + 1, "R7 drop not commit", n_commit - c0, 0);
    bus_start(); put_byte(8'hA0, a); put_byte(8'h10, a);
    bus_start(); put_byte(8'hA1, a); get_byte(1'b0, b); bus_stop();
    check(b == model[8'h10], "R7 dropped byte not stored", b, model[8'h10]);
    check(n_drop == d0 + 1 && n_commit == c0, "R7 no strobe without data", n_drop - d0, 1);

    // Master NACK: line stays released for later pulses
    bus_start(); put_byte(8'hA1, a); get_byte(1'b0, b);
    lows = 0;
    for (int k = 0; k < 9; k++) begin
      hq(); m_scl = 1'b1; hq();
      if (!sda_line) lows++;
      m_scl = 1'b0;
    end
    hq(); bus_stop();
    check(lows == 0, "R11 released after NACK", lows, 0);
    check(sda_oe == 1'b0, "R4 released after STOP", sda_oe, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule